// File: doc/BRIEF.md
# Byte-Wide Self-Synchronous Scrambler

This block whitens or restores a continuous byte stream with a self-synchronous scrambler. It sits between a byte-oriented link framer and a transport framer, so idle flags and frame contents pass through it alike. The block has no notion of where frames start or end. Each clock it takes one byte and returns one byte a cycle later. A 43-bit history register holds the most recent line bits, meaning the bits as they appear on the scrambled side. In scramble mode each output bit is the data bit XOR the line bit from 43 bit-times earlier. In descramble mode the same XOR is applied to the received bits. A build parameter adds a second feedback tap at 23 bit-times.

At start-up the transmit side may be given any 43-bit starting value. The receive side needs no start value: it recovers once 43 line bits have passed through it. A configuration input picks the order of the bits inside each byte. One order takes the most significant bit first, which is the order bits go onto the wire. The other takes the least significant bit first, which is the order the frame check is computed in. The two orders give different line streams and cannot talk to each other. A bypass setting passes bytes through unchanged and keeps the history current, so the link can interwork with a peer that does not scramble.

Top module: `selfsync_scrambler`

## Requirements
- R1: In scramble mode, two-tap build, each output bit equals the input bit XOR the output bit produced 43 bit-times earlier. Each output bit becomes the newest history bit.
- R2: In descramble mode, each output bit equals the received bit XOR the received bit from 43 bit-times earlier. The received bits, not the outputs, become the newest history bits.
- R3: With USE_MID_TAP=1, the feedback of each bit also XORs in the line bit from 23 bit-times earlier, in both modes.
- R4: A cycle with seed_load=1 sets the history to seed_value. The oldest bit, 43 bit-times back, is seed_value[42], and the newest is seed_value[0]. This takes priority over a byte offered in the same cycle: that byte is dropped, no output byte is produced, and dout holds its previous value.
- R5: A descrambler that starts from any history state produces the original plaintext for every bit from the 44th received bit onward. The 44th bit is bit-time 43, counting from 0.
- R6: In the two-tap build, one flipped line bit gives exactly two wrong descrambled bits: one at the same bit-time and one 43 bit-times later.
- R7: With cfg_lsb_first=0, the bits of a byte are processed din[7] first and din[0] last. With cfg_lsb_first=1, they are processed din[0] first. Either way, dout[i] is the result for din[i].
- R8: With cfg_bypass=1, dout equals din one cycle later, and the din bits enter the history in the selected order. After leaving bypass, the next bytes are exactly as if the bypassed bytes had been line bits.
- R9: synced is 0 from reset until at least 43 bits have been accepted since reset. It rises together with the output of the byte that crosses 43 bits (the 6th byte), and it stays 1 until reset.
- R10: dout_valid is din_valid AND NOT seed_load, delayed one cycle. A cycle without a valid byte leaves the history unchanged. Reset clears dout, dout_valid and synced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; clears the history |
| cfg_descramble | input | 1 | 0 = scramble, 1 = descramble |
| cfg_bypass | input | 1 | 1 = pass bytes unchanged while still updating the history |
| cfg_lsb_first | input | 1 | 0 = most significant bit first, 1 = least significant bit first |
| seed_load | input | 1 | Load seed_value into the history this cycle |
| seed_value | input | 43 | Start value for the history; bit 42 is the oldest |
| din | input | 8 | Input byte |
| din_valid | input | 1 | din carries a byte this cycle |
| dout | output | 8 | Output byte, registered |
| dout_valid | output | 1 | dout was updated by the last edge |
| synced | output | 1 | At least 43 bits have been accepted since reset |

## Verification
The properties compare state one cycle after a byte with the configuration sampled together with that byte. They therefore assume that the mode, order and bypass inputs describe the byte offered in the same cycle. The stimulus changes the configuration only at the falling edge, together with the byte it applies to. The receive-side history check assumes most-significant-first order, so it is gated by that setting. Seed loads are driven only while the link is otherwise idle or while the priority rule is under test, so the dropped byte is always one the bench expects to vanish.

// File: rtl/sss_pkg.sv
package sss_pkg;

  // Per-byte operating configuration carried into the bit engine
  typedef struct packed {
    logic descramble;
    logic bypass;
    logic lsb_first;
  } sss_cfg_t;

endpackage

// File: rtl/sss_unroll.sv
// Combinational engine: runs the bit recurrence DATA_W times in one cycle.
module sss_unroll
  import sss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HIST_LEN    = 43,
  parameter int MID_TAP     = 23,
  parameter bit USE_MID_TAP = 1'b0
) (
  input  logic [HIST_LEN-1:0] hist_i,
  input  logic [DATA_W-1:0]   data_i,
  input  sss_cfg_t            cfg_i,
  output logic [DATA_W-1:0]   data_o,
  output logic [HIST_LEN-1:0] hist_o
);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  always_comb begin : bit_chain
    logic [HIST_LEN-1:0] h;
    logic [DATA_W-1:0]   o;
    logic [IW-1:0]       pos;
    logic                fb;
    logic                ob;
    logic                sb;
    h = hist_i;
    o = '0;
    for (int j = 0; j < DATA_W; j++) begin
      pos = cfg_i.lsb_first ? IW'(j) : IW'(DATA_W - 1 - j);
      fb  = h[HIST_LEN-1];
      if (USE_MID_TAP) fb = fb ^ h[MID_TAP-1];
      ob  = cfg_i.bypass ? data_i[pos] : (data_i[pos] ^ fb);
      // line-side bit feeds the history
      sb  = (cfg_i.descramble || cfg_i.bypass) ? data_i[pos] : ob;
      o[pos] = ob;
      h = {h[HIST_LEN-2:0], sb};
    end
    data_o = o;
    hist_o = h;
  end

endmodule

// File: rtl/sss_hist.sv
// History register: seed load wins over a byte advance.
module sss_hist #(
  parameter int HIST_LEN = 43
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                seed_load,
  input  logic [HIST_LEN-1:0] seed_i,
  input  logic                adv_i,
  input  logic [HIST_LEN-1:0] next_i,
  output logic [HIST_LEN-1:0] hist_o
);
  logic [HIST_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)            hist_q <= '0;
    else if (seed_load) hist_q <= seed_i;
    else if (adv_i)     hist_q <= next_i;
  end

  assign hist_o = hist_q;

  p_seed_load_r4: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> hist_q == $past(seed_i));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !adv_i) |=> $stable(hist_q));

endmodule

// File: rtl/sss_sync.sv
// Sticky flag: at least HIST_LEN bits seen since reset.
module sss_sync #(
  parameter int DATA_W   = 8,
  parameter int HIST_LEN = 43
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_i,
  output logic synced_o
);
  localparam int CW = $clog2(HIST_LEN + DATA_W + 1);
  localparam logic [CW-1:0] STEP  = CW'(DATA_W);
  localparam logic [CW-1:0] LIMIT = CW'(HIST_LEN);

  logic [CW-1:0] cnt_q;
  logic          sync_q;
  logic [CW-1:0] cnt_nx;

  assign cnt_nx = cnt_q + STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else if (adv_i && !sync_q) begin
      cnt_q  <= cnt_nx;
      sync_q <= (cnt_nx >= LIMIT);
    end
  end

  assign synced_o = sync_q;

  p_sync_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> sync_q);

  p_sync_needs_data_r9: assert property (@(posedge clk) disable iff (rst)
    (!sync_q && !adv_i) |=> !sync_q);

endmodule

// File: rtl/selfsync_scrambler.sv
module selfsync_scrambler
  import sss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HIST_LEN    = 43,
  parameter int MID_TAP     = 23,
  parameter bit USE_MID_TAP = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_descramble,
  input  logic                cfg_bypass,
  input  logic                cfg_lsb_first,
  input  logic                seed_load,
  input  logic [HIST_LEN-1:0] seed_value,
  input  logic [DATA_W-1:0]   din,
  input  logic                din_valid,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_valid,
  output logic                synced
);
  sss_cfg_t            cfg;
  logic                adv;
  logic [HIST_LEN-1:0] hist_w;
  logic [HIST_LEN-1:0] hist_nx;
  logic [DATA_W-1:0]   byte_nx;
  logic [DATA_W-1:0]   dout_q;
  logic                dv_q;
  logic [DATA_W-1:0]   dout_rev;

  assign cfg = '{descramble: cfg_descramble, bypass: cfg_bypass, lsb_first: cfg_lsb_first};
  assign adv = din_valid && !seed_load;

  sss_unroll #(
    .DATA_W(DATA_W), .HIST_LEN(HIST_LEN), .MID_TAP(MID_TAP), .USE_MID_TAP(USE_MID_TAP)
  ) u_unroll (
    .hist_i(hist_w), .data_i(din), .cfg_i(cfg), .data_o(byte_nx), .hist_o(hist_nx)
  );

  sss_hist #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_i(seed_value),
    .adv_i(adv), .next_i(hist_nx), .hist_o(hist_w)
  );

  sss_sync #(.DATA_W(DATA_W), .HIST_LEN(HIST_LEN)) u_sync (
    .clk(clk), .rst(rst), .adv_i(adv), .synced_o(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      dv_q <= adv;
      if (adv) dout_q <= byte_nx;
    end
  end

  assign dout       = dout_q;
  assign dout_valid = dv_q;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign dout_rev[g] = dout_q[DATA_W-1-g];
  end

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
    adv |=> dout_valid);

  p_no_valid_r10: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !dout_valid);

  p_bypass_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && cfg_bypass) |=> dout == $past(din));

  p_tx_hist_msb_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && !cfg_descramble && !cfg_bypass && !cfg_lsb_first)
      |=> hist_w[DATA_W-1:0] == dout);

  p_tx_hist_lsb_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && !cfg_descramble && !cfg_bypass && cfg_lsb_first)
      |=> hist_w[DATA_W-1:0] == dout_rev);

  p_rx_hist_r2: assert property (@(posedge clk) disable iff (rst)
    (adv && cfg_descramble && !cfg_lsb_first)
      |=> hist_w[DATA_W-1:0] == $past(din));

endmodule

// File: tb/selfsync_scrambler_tb_top.sv
`timescale 1ns/1ps
module selfsync_scrambler_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_descramble, cfg_bypass, cfg_lsb_first;
  logic        seed_load;
  logic [42:0] seed_value;
  logic [7:0]  din;
  logic        din_valid;
  logic [7:0]  dout, dout3;
  logic        dout_valid, dout_valid3;
  logic        synced, synced3;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  selfsync_scrambler dut_i (
    .clk(clk), .rst(rst), .cfg_descramble(cfg_descramble), .cfg_bypass(cfg_bypass),
    .cfg_lsb_first(cfg_lsb_first), .seed_load(seed_load), .seed_value(seed_value),
    .din(din), .din_valid(din_valid), .dout(dout), .dout_valid(dout_valid), .synced(synced)
  );

  selfsync_scrambler #(.USE_MID_TAP(1'b1)) dut3_i (
    .clk(clk), .rst(rst), .cfg_descramble(cfg_descramble), .cfg_bypass(cfg_bypass),
    .cfg_lsb_first(cfg_lsb_first), .seed_load(seed_load), .seed_value(seed_value),
    .din(din), .din_valid(din_valid), .dout(dout3), .dout_valid(dout_valid3), .synced(synced3)
  );

  // {descramble, bypass, lsb_first, valid, data}
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    12'h17E, 12'h100, 12'h1FF, 12'h1A5, 12'h033, 12'h37E, 12'h3C3, 12'h301,
    12'h555, 12'h57D, 12'h000, 12'h17E, 12'h112, 12'h780, 12'h33C, 12'h97E,
    12'h9E1, 12'hB4D, 12'hD99, 12'h90F
  };

  // Bit-serial reference; h[42] is the bit 43 bit-times back
  function automatic logic [7:0] mstep(inout logic [42:0] h, input logic [7:0] d,
                                       input logic desc, input logic byp,
                                       input logic lsb, input logic three);
    logic [7:0] o;
    int p;
    logic fb, ob, sb;
    o = '0;
    for (int j = 0; j < 8; j++) begin
      p  = lsb ? j : 7 - j;
      fb = h[42] ^ (three & h[22]);
      ob = byp ? d[p] : (d[p] ^ fb);
      sb = (desc || byp) ? d[p] : ob;
      o[p] = ob;
      h = {h[41:0], sb};
    end
    return o;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    din_valid = 1'b0; seed_load = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [42:0] m2, m3, tx;
    logic [7:0]  e2, e3, p, sc, d;
    logic [11:0] v;
    rst = 1'b1; cfg_descramble = 0; cfg_bypass = 0; cfg_lsb_first = 0;
    seed_load = 0; seed_value = '0; din = '0; din_valid = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset dout_valid", 64'(dout_valid), 64'd0);
    chk("R10 reset dout", 64'(dout), 64'd0);
    chk("R9 reset synced", 64'(synced), 64'd0);
    rst = 1'b0;

    // R4: seed load beats a byte offered in the same cycle
    seed_load = 1'b1; seed_value = 43'h2B39D71C04F; din = 8'hEE; din_valid = 1'b1;
    @(negedge clk);
    chk("R4 seed cycle no output", 64'(dout_valid), 64'd0);
    chk("R4 seed cycle dout held", 64'(dout), 64'd0);
    chk("R4 seed cycle not counted", 64'(synced), 64'd0);
    seed_load = 1'b0; din_valid = 1'b0;
    m2 = 43'h2B39D71C04F; m3 = m2;

    // Table: R1 R2 R3 R7 R8 R10 across modes, orders and bypass
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      cfg_descramble = v[11]; cfg_bypass = v[10]; cfg_lsb_first = v[9];
      din_valid = v[8]; din = v[7:0];
      e2 = 8'h00; e3 = 8'h00;
      if (v[8]) begin
        e2 = mstep(m2, v[7:0], v[11], v[10], v[9], 1'b0);
        e3 = mstep(m3, v[7:0], v[11], v[10], v[9], 1'b1);
      end
      @(negedge clk);
      chk("R10 table dout_valid", 64'(dout_valid), 64'(v[8]));
      if (v[8]) begin
        chk("R1 R2 R7 R8 table two-tap dout", 64'(dout), 64'(e2));
        chk("R3 table three-tap dout", 64'(dout3), 64'(e3));
      end
    end
    din_valid = 1'b0;

    // R5 and R9: descrambler from zero history locks onto a seeded stream
    do_reset();
    cfg_descramble = 1'b1; cfg_bypass = 1'b0; cfg_lsb_first = 1'b0;
    tx = 43'h3A5C3F09E17;
    for (int i = 0; i < 12; i++) begin
      p  = 8'(i * 37 + 11);
      sc = mstep(tx, p, 1'b0, 1'b0, 1'b0, 1'b0);
      din = sc; din_valid = 1'b1;
      @(negedge clk);
      if (i >= 6) chk("R5 converged plaintext", 64'(dout), 64'(p));
      if (i == 4) chk("R9 not synced after 40 bits", 64'(synced), 64'd0);
      if (i == 5) chk("R9 synced after 48 bits", 64'(synced), 64'd1);
    end
    din_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 synced sticky while idle", 64'(synced), 64'd1);
    chk("R10 idle no dout_valid", 64'(dout_valid), 64'd0);

    // R6: one flipped line bit (bit-time 8) gives errors at 8 and 51
    do_reset();
    cfg_descramble = 1'b1; cfg_bypass = 1'b0; cfg_lsb_first = 1'b0;
    for (int i = 0; i < 12; i++) begin
      d = (i == 1) ? 8'h80 : 8'h00;
      din = d; din_valid = 1'b1;
      @(negedge clk);
      chk("R6 error multiplication byte", 64'(dout),
          (i == 1) ? 64'h80 : ((i == 6) ? 64'h10 : 64'h00));
    end
    din_valid = 1'b0;

    // R7: the same byte from the same state differs by order
    do_reset();
    seed_load = 1'b1; seed_value = 43'h40000000001; @(negedge clk);
    seed_load = 1'b0;
    cfg_descramble = 1'b0; cfg_lsb_first = 1'b1;
    m2 = 43'h40000000001;
    e2 = mstep(m2, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    din = 8'h00; din_valid = 1'b1; @(negedge clk);
    din_valid = 1'b0;
    chk("R7 lsb-first first output", 64'(dout), 64'(e2));
    chk("R7 lsb-first oldest bit lands in dout[0]", 64'(dout), 64'h01);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule